// File: doc/BRIEF.md
# Reload Timer PWM Generator

An up-counting timer that drives a single pulse-width-modulated pin. The counter runs towards its all-ones value; on the step past it, an overflow event occurs and the counter restarts from a programmable reload value. So the period is set by how far below the overflow point the reload value sits. The pin is toggled by the overflow event, by the counter reaching a programmable compare value, or by both. Each source has its own enable.

Software writes four registers through a one-cycle write strobe: a configuration word, the live count, the reload value and the compare value. Reload and compare writes land in shadow copies. Both values take effect together at the next overflow, so a period already under way keeps its old timing and duty. While the timer is stopped, the pin rests at a programmable idle level, and the configuration can only be rewritten in that state.

To produce a period of P cycles with D high cycles (1 <= D < P, idle level low), software writes reload = MAX - P + 1, compare = reload + D - 1 and count = MAX. It then starts the timer with both toggle sources enabled.

Top module: `reload_pwm_timer`

## Requirements
- R1: While the run bit is set, the count rises by one on each clock. While it is clear, the count holds its value.
- R2: With the count at all-ones and the run bit set, the next clock reloads the count from the reload shadow. When auto-reload (config bit 1) is clear, that same clock also clears the run bit, so the timer stops after one overflow.
- R3: The pin inverts on an overflow when config bit 2 is set. It inverts on count == compare when config bit 3 is set. If both events fire in one cycle with both enabled, the two inversions cancel and the pin keeps its level.
- R4: With reload = MAX - P + 1, compare = reload + D - 1, count preset to MAX, idle level 0 and both toggles enabled, the pin repeats a waveform of exactly P cycles, high for exactly D of them. A compare equal to the reload value gives one high cycle.
- R5: Reload and compare writes made while running do not alter the period in progress. Both take effect together from the period that starts at the next overflow. While stopped, the compare in use follows its shadow.
- R6: The configuration word holds run (bit 0), auto-reload (bit 1), overflow toggle (bit 2), compare toggle (bit 3) and idle level (bit 4). A configuration write while running changes only the run bit; all other bits keep their values.
- R7: A count write replaces the count at the next clock. It takes priority over the overflow reload when both happen in the same cycle.
- R8: Whenever the run bit is clear, the pin equals the idle level. A configuration write that clears run forces the pin to idle from the following clock.
- R9: The write select chooses the configuration (0), the count (1), the reload (2) or the compare (3). Reset clears all registers, so the pin is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per asserted cycle |
| wr_sel | input | 2 | Register select: 0 config, 1 count, 2 reload, 3 compare |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | PWM pin |

## Verification
The bench changes reload and compare partway through a high phase. A design that applied the shadows at once would distort the measured period, while one applying only one of them would mix old duty with new period. A count write placed exactly on the overflow cycle shows whether the write beats the reload: with the wrong priority, the following high phase is the programmed duty rather than the run to overflow. The bench also checks that coincident overflow and compare events cancel, that a single-shot timer reloads and then stops, and that configuration writes during a run leave the waveform and idle level untouched. Randomly chosen period and duty pairs are checked against the R4 arithmetic, along with a compare equal to the reload value.

// File: rtl/reload_pwm_pkg.sv
package reload_pwm_pkg;

  typedef enum logic [1:0] {
    SEL_CFG   = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_RELOAD= 2'd2,
    SEL_CMP   = 2'd3
  } reg_sel_e;

  localparam int CFG_W = 5;

  // bit 0 run, 1 auto-reload, 2 toggle on overflow, 3 toggle on compare, 4 idle level
  typedef struct packed {
    logic idle_lvl;
    logic tog_cmp;
    logic tog_ovf;
    logic auto_rl;
    logic run;
  } cfg_t;

  function automatic logic pin_next(input logic cur, input logic ovf_hit,
                                    input logic cmp_hit);
    return cur ^ ovf_hit ^ cmp_hit;
  endfunction

endpackage

// File: rtl/reload_pwm_cfg.sv
module reload_pwm_cfg
  import reload_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             ovf_evt,
  output cfg_t             cfg_q
);
  cfg_t wr_word;
  assign wr_word = cfg_t'(cfg_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      if (cfg_wr) begin
        if (cfg_q.run) cfg_q.run <= wr_word.run;
        else           cfg_q     <= wr_word;
      end
      if (ovf_evt && !cfg_q.auto_rl) cfg_q.run <= 1'b0;
    end
  end
endmodule

// File: rtl/reload_pwm_shadow.sv
module reload_pwm_shadow #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] wr_data,
  input  logic         running,
  input  logic         ovf_evt,
  output logic [W-1:0] sh_reload,
  output logic [W-1:0] act_cmp
);
  logic [W-1:0] sh_cmp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_reload <= '0;
      sh_cmp    <= '0;
      act_cmp   <= '0;
    end else begin
      if (reload_wr) sh_reload <= wr_data;
      if (cmp_wr)    sh_cmp    <= wr_data;
      if (!running || ovf_evt) act_cmp <= sh_cmp;
    end
  end
endmodule

// File: rtl/reload_pwm_counter.sv
module reload_pwm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         running,
  input  logic         cnt_wr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] count_q,
  output logic         ovf_evt
);
  localparam logic [W-1:0] TOP = '1;

  function automatic logic [W-1:0] step(input logic [W-1:0] cur, input logic run,
                                        input logic ovf, input logic wr,
                                        input logic [W-1:0] wval,
                                        input logic [W-1:0] rl);
    if (wr)  return wval;
    if (ovf) return rl;
    if (run) return cur + 1'b1;
    return cur;
  endfunction

  assign ovf_evt = running && (count_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= step(count_q, running, ovf_evt, cnt_wr, wr_data, reload_val);
  end
endmodule

// File: rtl/reload_pwm_pin.sv
module reload_pwm_pin
  import reload_pwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic idle_lvl,
  input  logic tog_ovf,
  input  logic tog_cmp,
  input  logic ovf_evt,
  input  logic cmp_evt,
  output logic pwm_out
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        pin_q <= 1'b0;
    else if (!running) pin_q <= idle_lvl;
    else               pin_q <= pin_next(pin_q, tog_ovf && ovf_evt, tog_cmp && cmp_evt);
  end

  assign pwm_out = running ? pin_q : idle_lvl;
endmodule

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer
  import reload_pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out
);
  cfg_t             cfg_q;
  logic             running;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] sh_reload;
  logic [CNT_W-1:0] act_cmp;
  logic             ovf_evt;
  logic             cmp_evt;
  logic             cfg_wr, cnt_wr, reload_wr, cmp_wr;

  assign cfg_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_CFG);
  assign cnt_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
  assign reload_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_RELOAD);
  assign cmp_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_CMP);

  assign running = cfg_q.run;
  assign cmp_evt = running && (count_q == act_cmp);

  reload_pwm_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_data (wr_data[CFG_W-1:0]),
    .ovf_evt  (ovf_evt),
    .cfg_q    (cfg_q)
  );

  reload_pwm_shadow #(.W(CNT_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload_wr (reload_wr),
    .cmp_wr    (cmp_wr),
    .wr_data   (wr_data),
    .running   (running),
    .ovf_evt   (ovf_evt),
    .sh_reload (sh_reload),
    .act_cmp   (act_cmp)
  );

  reload_pwm_counter #(.W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .cnt_wr     (cnt_wr),
    .wr_data    (wr_data),
    .reload_val (sh_reload),
    .count_q    (count_q),
    .ovf_evt    (ovf_evt)
  );

  reload_pwm_pin u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (running),
    .idle_lvl (cfg_q.idle_lvl),
    .tog_ovf  (cfg_q.tog_ovf),
    .tog_cmp  (cfg_q.tog_cmp),
    .ovf_evt  (ovf_evt),
    .cmp_evt  (cmp_evt),
    .pwm_out  (pwm_out)
  );
endmodule

// File: rtl/reload_pwm_checker.sv
module reload_pwm_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_wr,
  input logic         wr_run,
  input logic         cnt_wr,
  input logic [W-1:0] wr_data,
  input logic         running,
  input logic [3:0]   cfg_rest,
  input logic         auto_rl,
  input logic         tog_ovf,
  input logic         tog_cmp,
  input logic         idle_lvl,
  input logic [W-1:0] count_q,
  input logic [W-1:0] sh_reload,
  input logic [W-1:0] act_cmp,
  input logic         ovf_evt,
  input logic         cmp_evt,
  input logic         pwm_out
);
  a_r1_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    running && !ovf_evt && !cnt_wr |=> count_q == $past(count_q) + 1'b1);

  a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !cnt_wr |=> $stable(count_q));

  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !cnt_wr |=> count_q == $past(sh_reload));

  a_r2_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !auto_rl |=> !running);

  a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    running && auto_rl && !cfg_wr && ((ovf_evt && tog_ovf) != (cmp_evt && tog_cmp))
    |=> pwm_out != $past(pwm_out));

  a_r5_cmp_held: assert property (@(posedge clk) disable iff (!rst_n)
    running && !ovf_evt |=> $stable(act_cmp));

  a_r6_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    running && cfg_wr |=> $stable(cfg_rest));

  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count_q == $past(wr_data));

  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    running && cfg_wr && !wr_run |=> pwm_out == idle_lvl);
endmodule

bind reload_pwm_timer reload_pwm_checker #(.W(CNT_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .wr_run    (wr_data[0]),
  .cnt_wr    (cnt_wr),
  .wr_data   (wr_data),
  .running   (running),
  .cfg_rest  ({cfg_q.idle_lvl, cfg_q.tog_cmp, cfg_q.tog_ovf, cfg_q.auto_rl}),
  .auto_rl   (cfg_q.auto_rl),
  .tog_ovf   (cfg_q.tog_ovf),
  .tog_cmp   (cfg_q.tog_cmp),
  .idle_lvl  (cfg_q.idle_lvl),
  .count_q   (count_q),
  .sh_reload (sh_reload),
  .act_cmp   (act_cmp),
  .ovf_evt   (ovf_evt),
  .cmp_evt   (cmp_evt),
  .pwm_out   (pwm_out)
);

// File: tb/reload_pwm_timer_test.sv
module reload_pwm_timer_test;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] B_RUN = 1, B_AUTO = 2, B_TOVF = 4, B_TCMP = 8, B_IDLE = 16;
  localparam logic [1:0] S_CFG = 0, S_CNT = 1, S_RL = 2, S_CMP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic pwm_out;
  int tests = 0;
  int fails = 0;

  reload_pwm_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] reload_for(input int p);
    return MAXV - W'(p) + 1;
  endfunction

  function automatic logic [W-1:0] cmp_for(input logic [W-1:0] rl, input int d);
    return rl + W'(d) - 1;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns at the falling edge after capture
  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_rise();
    logic p;
    p = pwm_out;
    forever begin
      @(negedge clk);
      if (!p && pwm_out) break;
      p = pwm_out;
    end
  endtask

  // starts at a sample where the pin has just risen, ends at the next rise sample
  task automatic measure(output int hi, output int per);
    int lo;
    hi = 1;
    @(negedge clk);
    while (pwm_out) begin hi++; @(negedge clk); end
    lo = 1;
    @(negedge clk);
    while (!pwm_out) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic count_rises(input int n, output int r);
    logic p;
    r = 0;
    p = pwm_out;
    repeat (n) begin
      @(negedge clk);
      if (!p && pwm_out) r++;
      p = pwm_out;
    end
  endtask

  task automatic launch(input int p, input int d, input logic [W-1:0] cfg);
    logic [W-1:0] rl;
    rl = reload_for(p);
    wr(S_RL, rl);
    wr(S_CMP, cmp_for(rl, d));
    wr(S_CNT, MAXV);
    wr(S_CFG, cfg);
  endtask

  localparam logic [W-1:0] STD = B_RUN | B_AUTO | B_TOVF | B_TCMP;

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int hi, per, r, p, d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset pin low", pwm_out, 0);

    // R4 R1: random period/duty pairs
    for (int i = 0; i < 6; i++) begin
      p = 2 + int'($urandom % 40);
      d = 1 + int'($urandom % (p - 1));
      launch(p, d, STD);
      sync_rise();
      measure(hi, per);
      check("R4 R1 high time", hi, d);
      check("R4 R1 period", per, p);
      wr(S_CFG, 0);
    end

    // R4: compare equal to reload -> one high cycle
    launch(5, 1, STD);
    sync_rise();
    measure(hi, per);
    check("R4 cmp==reload high", hi, 1);
    check("R4 cmp==reload period", per, 5);
    wr(S_CFG, 0);

    // R5: mid-period update of both shadows
    launch(20, 8, STD);
    sync_rise();
    fork
      measure(hi, per);
      begin
        wr(S_RL, reload_for(12));
        wr(S_CMP, cmp_for(reload_for(12), 3));
      end
    join
    check("R5 current period high kept", hi, 8);
    check("R5 current period length kept", per, 20);
    measure(hi, per);
    check("R5 next period high new", hi, 3);
    check("R5 next period length new", per, 12);
    wr(S_CFG, 0);

    // R6 R8: config writes while running only touch run
    launch(10, 4, STD);
    wr(S_CFG, B_RUN | B_IDLE);
    sync_rise();
    measure(hi, per);
    check("R6 waveform high unchanged", hi, 4);
    check("R6 waveform period unchanged", per, 10);
    wr(S_CFG, 0);
    check("R6 R8 idle level not taken, pin low", pwm_out, 0);

    // R8: idle level while stopped and on stop
    wr(S_CFG, B_IDLE);
    check("R8 stopped pin at idle high", pwm_out, 1);
    launch(8, 3, STD | B_IDLE);
    repeat (5) @(negedge clk);
    wr(S_CFG, B_IDLE);
    check("R8 stop forces idle high", pwm_out, 1);
    wr(S_CFG, 0);
    check("R8 idle low after reconfig", pwm_out, 0);

    // R3: compare-only toggling gives a square of twice the period
    launch(6, 3, B_RUN | B_AUTO | B_TCMP);
    sync_rise();
    measure(hi, per);
    check("R3 compare-only high", hi, 6);
    check("R3 compare-only period", per, 12);
    wr(S_CFG, 0);

    // R3: coincident overflow and compare cancel
    wr(S_RL, reload_for(8));
    wr(S_CMP, MAXV);
    wr(S_CNT, MAXV);
    wr(S_CFG, STD);
    count_rises(40, r);
    check("R3 coincident toggles cancel", r, 0);
    wr(S_CFG, 0);

    // R2: single shot, then restart from reloaded count
    wr(S_RL, reload_for(4));
    wr(S_CMP, reload_for(4) + 1);
    wr(S_CNT, reload_for(4));
    wr(S_CFG, B_RUN | B_TOVF | B_TCMP);
    count_rises(20, r);
    check("R2 single shot one pulse then stop", r, 1);
    wr(S_CFG, B_RUN | B_TOVF | B_TCMP);
    count_rises(20, r);
    check("R2 R1 restart from reloaded count", r, 1);
    wr(S_CFG, 0);

    // R7: count write coinciding with overflow beats reload
    launch(16, 3, STD);
    sync_rise();
    repeat (15) @(negedge clk);
    wr(S_CNT, MAXV - 9);
    check("R7 pin high after coincident write", pwm_out, 1);
    measure(hi, per);
    check("R7 write wins high run", hi, 10);
    check("R7 write wins following period", per, 13);
    wr(S_CFG, 0);

    // R9 R7: plain count write while stopped then start
    wr(S_RL, reload_for(6));
    wr(S_CMP, cmp_for(reload_for(6), 2));
    wr(S_CNT, MAXV - 2);
    wr(S_CFG, STD);
    @(negedge clk); @(negedge clk);
    check("R9 R7 pin low before overflow", pwm_out, 0);
    @(negedge clk);
    check("R9 R7 pin high after overflow", pwm_out, 1);
    wr(S_CFG, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule